// File: doc/BRIEF.md
# Vectored Interrupt Arbiter with Acknowledge

This block gathers interrupt requests from nineteen sources and presents them to a processor as one maskable request line and one vector byte. Each source owns a 16-bit control word. The word holds the source's vector number, a pending flag, two enable bits and a forced flag. A request input is sampled as a level. A rising edge on an enabled source marks that source pending, and a falling edge withdraws it.

When nothing is in service, the arbiter picks the lowest-numbered pending source. It latches that source as the current one and raises the request line. The choice then stays frozen until the processor acknowledges or the current source withdraws its request. A maskable acknowledge clears the current source's pending flag and returns its vector byte. In the same edge the arbiter scans again, so the next pending source is selected without a gap.

A separate non-maskable output is raised by a set strobe. It is dropped by its own acknowledge strobe, which returns zero. Software can write a control word. A write that carries the pending bit is recorded as a forced request: the forced bit is set and the pending bit is cleared. A read port shows any stored word.

Top module: `vec_irq_arbiter`

## Requirements
- R1: Each of the 19 control words is laid out as follows: bits 7:0 hold the vector, bit 8 is pending, bit 9 is external enable, bit 10 is internal enable and bit 11 is forced. Bits 15:12 are stored as written. All words, the latch and the outputs are zero after reset.
- R2: A rising edge on `src_req[i]` sets bit 8 of word i at the clock edge where it is sampled. This happens only if bit 9 or bit 10 of word i is set. A rising edge on a source with both enables clear leaves the word unchanged.
- R3: A falling edge on `src_req[i]` clears bit 8 of word i. If source i is the current source while active, the latch is released and a new scan happens at the same edge. A withdrawal of any other source leaves the line and the current source unchanged.
- R4: While the latch is active, new pending sources do not change `irq_out` or `vec_out`.
- R5: While the latch is idle, the lowest-indexed source whose bit 8 is set becomes current. In that case `irq_out` is high after the same edge that set the flag.
- R6: A maskable acknowledge while active does several things at one edge. It returns the acknowledged vector byte on `ack_data`, with `ack_valid` high for one cycle. It clears that source's bit 8 and rescans. `irq_out` stays high only if another source is pending.
- R7: A maskable acknowledge while idle returns the last current vector byte and changes no stored state.
- R8: `vec_out` always shows bits 7:0 of the current source's word. Observing it has no side effect.
- R9: A write whose data has bit 8 set stores the data with bit 11 set and bit 8 clear. Any other write stores the data unchanged.
- R10: `nmi_set` raises `nmi_out`. `ack_nmi` lowers it and returns zero on `ack_data` with `ack_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 19 | Per-source request levels |
| wr_en | input | 1 | Control word write strobe |
| wr_idx | input | 5 | Source index for the write |
| wr_data | input | 16 | Write data |
| rd_idx | input | 5 | Source index for the read port |
| rd_data | output | 16 | Stored control word of `rd_idx` (zero if out of range) |
| ack_irq | input | 1 | Maskable acknowledge strobe |
| nmi_set | input | 1 | Raise the non-maskable line |
| ack_nmi | input | 1 | Non-maskable acknowledge strobe |
| irq_out | output | 1 | Maskable interrupt request line |
| nmi_out | output | 1 | Non-maskable interrupt line |
| vec_out | output | 8 | Vector byte of the current source |
| ack_valid | output | 1 | One-cycle pulse after an acknowledge |
| ack_data | output | 8 | Value returned by the last acknowledge |

## Verification
The bench raises a second source while a first is in service. A design without the active latch would switch `vec_out` early and lose the first vector. Two sources requested together must resolve to the lower index, and a design with the scan reversed would report the higher vector. After an acknowledge with another source pending, the line must stay up with the new vector. If the acknowledge went idle there, the second request would be lost. If it failed to clear the served pending flag, the same vector would be returned twice.

The bench also covers several edge cases:
- An idle acknowledge must return the stale vector and must not corrupt any word.
- Withdrawing the current source must move service to the next pending source, while withdrawing an unrelated source must not.
- A write carrying the pending bit must appear as forced rather than pending.

// File: rtl/virq_pkg.sv
package virq_pkg;
    // Bit positions inside each source control word
    localparam int VEC_W      = 8;
    localparam int PEND_BIT   = 8;
    localparam int EXT_EN_BIT = 9;
    localparam int INT_EN_BIT = 10;
    localparam int FORCE_BIT  = 11;
endpackage

// File: rtl/virq_src_bank.sv
module virq_src_bank
    import virq_pkg::*;
#(
    parameter int NUM_SRC = 19,
    parameter int REG_W   = 16,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       src_req,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [REG_W-1:0]         wr_data,
    input  logic                     clr_en,
    input  logic [IDX_W-1:0]         clr_idx,
    output logic [NUM_SRC*REG_W-1:0] regs_flat,
    output logic [NUM_SRC-1:0]       pend_next,
    output logic [NUM_SRC-1:0]       fall_o
);

    typedef struct packed {
        logic [REG_W-1:0] ctl;
        logic             req;
    } slot_t;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
        slot_t slot_d, slot_q;
        logic  rise, fall, enabled;

        assign rise    = src_req[g] & ~slot_q.req;
        assign fall    = ~src_req[g] & slot_q.req;
        assign enabled = slot_q.ctl[EXT_EN_BIT] | slot_q.ctl[INT_EN_BIT];

        always_comb begin
            slot_d     = slot_q;
            slot_d.req = src_req[g];
            // software write; a pending bit in the data becomes forced (R9)
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                slot_d.ctl = wr_data;
                if (wr_data[PEND_BIT]) begin
                    slot_d.ctl[FORCE_BIT] = 1'b1;
                    slot_d.ctl[PEND_BIT]  = 1'b0;
                end
            end
            // acknowledge of the served source (R6)
            if (clr_en && (clr_idx == IDX_W'(g)))
                slot_d.ctl[PEND_BIT] = 1'b0;
            // request edges (R2, R3)
            if (rise && enabled)
                slot_d.ctl[PEND_BIT] = 1'b1;
            if (fall)
                slot_d.ctl[PEND_BIT] = 1'b0;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) slot_q <= '0;
            else        slot_q <= slot_d;
        end

        assign regs_flat[g*REG_W +: REG_W] = slot_q.ctl;
        assign pend_next[g]                = slot_d.ctl[PEND_BIT];
        assign fall_o[g]                   = fall;
    end

endmodule

// File: rtl/virq_prio_pick.sv
module virq_prio_pick #(
    parameter int NUM_SRC = 19,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] pend,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);

    // lowest index wins: scan downward so the last hit is the smallest
    always_comb begin
        idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend[i]) idx = IDX_W'(i);
        end
    end

    assign found = |pend;

endmodule

// File: rtl/vec_irq_arbiter.sv
module vec_irq_arbiter
    import virq_pkg::*;
#(
    parameter  int NUM_SRC = 19,
    parameter  int REG_W   = 16,
    localparam int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [REG_W-1:0]   wr_data,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [REG_W-1:0]   rd_data,
    input  logic               ack_irq,
    input  logic               nmi_set,
    input  logic               ack_nmi,
    output logic               irq_out,
    output logic               nmi_out,
    output logic [VEC_W-1:0]   vec_out,
    output logic               ack_valid,
    output logic [VEC_W-1:0]   ack_data
);

    typedef struct packed {
        logic             active;
        logic [IDX_W-1:0] cur;
        logic             nmi;
        logic             ack_v;
        logic [VEC_W-1:0] ack_d;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_SRC*REG_W-1:0] regs_flat;
    logic [REG_W-1:0]         regs_a [NUM_SRC];
    logic [NUM_SRC-1:0]       pend_next, fall_v;
    logic                     pick_found;
    logic [IDX_W-1:0]         pick_idx;
    logic [IDX_W-1:0]         cur_idx;
    logic [VEC_W-1:0]         cur_vec;
    logic                     clr_en, release_cur, busy;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_view
        assign regs_a[g] = regs_flat[g*REG_W +: REG_W];
    end

    assign cur_idx = ctl_q.cur;
    assign cur_vec = regs_a[cur_idx][VEC_W-1:0];
    assign clr_en  = ack_irq & ctl_q.active;

    virq_src_bank #(
        .NUM_SRC (NUM_SRC),
        .REG_W   (REG_W),
        .IDX_W   (IDX_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_req   (src_req),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .clr_en    (clr_en),
        .clr_idx   (cur_idx),
        .regs_flat (regs_flat),
        .pend_next (pend_next),
        .fall_o    (fall_v)
    );

    virq_prio_pick #(
        .NUM_SRC (NUM_SRC),
        .IDX_W   (IDX_W)
    ) u_pick (
        .pend  (pend_next),
        .found (pick_found),
        .idx   (pick_idx)
    );

    assign release_cur = clr_en | (ctl_q.active & fall_v[cur_idx]);
    assign busy        = ctl_q.active & ~release_cur;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.ack_v = 1'b0;
        if (nmi_set) ctl_d.nmi = 1'b1;
        if (ack_nmi) begin
            ctl_d.nmi   = 1'b0;
            ctl_d.ack_v = 1'b1;
            ctl_d.ack_d = '0;
        end
        if (ack_irq) begin
            ctl_d.ack_v = 1'b1;
            ctl_d.ack_d = cur_vec;
        end
        if (!busy) begin
            ctl_d.active = pick_found;
            if (pick_found) ctl_d.cur = pick_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign irq_out   = ctl_q.active;
    assign nmi_out   = ctl_q.nmi;
    assign vec_out   = cur_vec;
    assign ack_valid = ctl_q.ack_v;
    assign ack_data  = ctl_q.ack_d;
    assign rd_data   = (rd_idx < IDX_W'(NUM_SRC)) ? regs_a[rd_idx] : '0;

endmodule

// File: rtl/virq_checker.sv
module virq_checker
    import virq_pkg::*;
#(
    parameter  int NUM_SRC = 19,
    parameter  int REG_W   = 16,
    localparam int IDX_W   = $clog2(NUM_SRC)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_SRC-1:0]       src_req,
    input logic                     wr_en,
    input logic [IDX_W-1:0]         wr_idx,
    input logic                     wr_pend,
    input logic                     ack_irq,
    input logic                     ack_nmi,
    input logic                     irq_out,
    input logic                     nmi_out,
    input logic [VEC_W-1:0]         vec_out,
    input logic                     ack_valid,
    input logic [VEC_W-1:0]         ack_data,
    input logic [IDX_W-1:0]         cur_idx,
    input logic [NUM_SRC*REG_W-1:0] regs_flat
);

    p_hold_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !ack_irq && src_req[cur_idx]) |=> (irq_out && $stable(cur_idx)));

    p_ack_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_irq |=> (ack_valid && ack_data == $past(vec_out)));

    p_forced_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_pend && wr_idx < IDX_W'(NUM_SRC) && !src_req[wr_idx])
        |=> (!regs_flat[$past(wr_idx)*REG_W + PEND_BIT]
             && regs_flat[$past(wr_idx)*REG_W + FORCE_BIT]));

    p_nmi_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_nmi && !ack_irq) |=> (!nmi_out && ack_valid && ack_data == '0));

endmodule

bind vec_irq_arbiter virq_checker #(
    .NUM_SRC (NUM_SRC),
    .REG_W   (REG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_req   (src_req),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_pend   (wr_data[8]),
    .ack_irq   (ack_irq),
    .ack_nmi   (ack_nmi),
    .irq_out   (irq_out),
    .nmi_out   (nmi_out),
    .vec_out   (vec_out),
    .ack_valid (ack_valid),
    .ack_data  (ack_data),
    .cur_idx   (cur_idx),
    .regs_flat (regs_flat)
);

// File: tb/vec_irq_arbiter_test.sv
`timescale 1ns/1ps
module vec_irq_arbiter_test;

    localparam int N = 19;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] src_req = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [15:0] wr_data = '0;
    logic [4:0]  rd_idx = '0;
    logic [15:0] rd_data;
    logic        ack_irq = 1'b0, nmi_set = 1'b0, ack_nmi = 1'b0;
    logic        irq_out, nmi_out, ack_valid;
    logic [7:0]  vec_out, ack_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [7:0] v;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    vec_irq_arbiter uut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data),
        .ack_irq(ack_irq), .nmi_set(nmi_set), .ack_nmi(ack_nmi),
        .irq_out(irq_out), .nmi_out(nmi_out), .vec_out(vec_out),
        .ack_valid(ack_valid), .ack_data(ack_data)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input int idx, input logic [15:0] data);
        wr_en = 1'b1; wr_idx = 5'(idx); wr_data = data;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(string tag, input int idx, input logic [15:0] exp);
        rd_idx = 5'(idx);
        #1;
        check(tag, 32'(rd_data), 32'(exp));
    endtask

    // driver: pushes the expected returned byte, then strobes acknowledge
    task automatic do_ack(input logic [7:0] exp, string tag);
        exp_t e;
        e.v = exp; e.tag = tag;
        exp_q.push_back(e);
        ack_irq = 1'b1;
        tick();
        ack_irq = 1'b0;
    endtask

    task automatic do_nmi_ack(string tag);
        exp_t e;
        e.v = 8'h00; e.tag = tag;
        exp_q.push_back(e);
        ack_nmi = 1'b1;
        tick();
        ack_nmi = 1'b0;
    endtask

    // monitor: pops one expected item per returned acknowledge
    always @(negedge clk) begin
        if (rst_n && ack_valid) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL unexpected ack actual=0x%0h expected=none", ack_data);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, 32'(ack_data), 32'(e.v));
            end
        end
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        check("R1 irq reset", 32'(irq_out), 0);
        check("R1 nmi reset", 32'(nmi_out), 0);
        check("R1 ack_valid reset", 32'(ack_valid), 0);
        rd_chk("R1 word0 reset", 0, 16'h0000);

        // R2 disabled source ignored
        wr(3, 16'h0033);
        src_req[3] = 1'b1;
        tick();
        rd_chk("R2 disabled pend", 3, 16'h0033);
        check("R2 disabled irq", 32'(irq_out), 0);

        // R2/R5 enabled via external enable
        wr(5, 16'h0255);
        src_req[5] = 1'b1;
        tick();
        check("R5 irq asserted", 32'(irq_out), 1);
        check("R8 vec current", 32'(vec_out), 32'h55);
        rd_chk("R2 pend set", 5, 16'h0355);

        // R4 new request while active
        wr(2, 16'h0422);
        src_req[2] = 1'b1;
        tick();
        check("R4 irq held", 32'(irq_out), 1);
        check("R4 vec held", 32'(vec_out), 32'h55);
        rd_chk("R4 second pend", 2, 16'h0522);
        tick();
        check("R8 query no effect", 32'(vec_out), 32'h55);
        rd_chk("R8 word unchanged", 5, 16'h0355);

        // R6 acknowledge and immediate rescan
        do_ack(8'h55, "R6 ack vec first");
        check("R6 irq stays for next", 32'(irq_out), 1);
        check("R6 next vec", 32'(vec_out), 32'h22);
        rd_chk("R6 served pend cleared", 5, 16'h0255);
        do_ack(8'h22, "R6 ack vec second");
        check("R6 irq drops", 32'(irq_out), 0);
        rd_chk("R6 second pend cleared", 2, 16'h0422);

        // R7 acknowledge while idle
        do_ack(8'h22, "R7 idle ack stale vec");
        check("R7 irq idle", 32'(irq_out), 0);
        rd_chk("R7 word2 unchanged", 2, 16'h0422);
        rd_chk("R7 word5 unchanged", 5, 16'h0255);

        src_req = '0;
        tick();

        // R5 fixed priority, simultaneous requests
        wr(9, 16'h0299);
        wr(4, 16'h0444);
        src_req[9] = 1'b1;
        src_req[4] = 1'b1;
        tick();
        check("R5 lowest index wins", 32'(vec_out), 32'h44);

        // R3 withdrawal of a non-current source
        src_req[9] = 1'b0;
        tick();
        check("R3 other withdraw irq", 32'(irq_out), 1);
        check("R3 other withdraw vec", 32'(vec_out), 32'h44);
        rd_chk("R3 withdrawn pend cleared", 9, 16'h0299);

        // R3 withdrawal of the current source
        src_req[9] = 1'b1;
        tick();
        src_req[4] = 1'b0;
        tick();
        check("R3 current withdraw rescan irq", 32'(irq_out), 1);
        check("R3 current withdraw rescan vec", 32'(vec_out), 32'h99);
        rd_chk("R3 current pend cleared", 4, 16'h0444);
        src_req[9] = 1'b0;
        tick();
        check("R3 last withdraw idle", 32'(irq_out), 0);

        // R9 forced write
        wr(10, 16'h01AA);
        rd_chk("R9 forced instead of pending", 10, 16'h08AA);
        check("R9 forced no irq", 32'(irq_out), 0);
        wr(11, 16'hF2AB);
        rd_chk("R1 R9 plain write stored", 11, 16'hF2AB);

        // R10 NMI
        nmi_set = 1'b1;
        tick();
        nmi_set = 1'b0;
        check("R10 nmi raised", 32'(nmi_out), 1);
        do_nmi_ack("R10 nmi ack zero");
        check("R10 nmi dropped", 32'(nmi_out), 0);

        tick();
        check("scoreboard drained", 32'(exp_q.size()), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule